// File: doc/BRIEF.md
# Time-Slot Interchanger with Per-Channel Delay Mode

This block switches 8-bit channel samples between time-division-multiplexed serial streams on an 8 kHz frame. Four input and four output streams each carry 32 channels, sent MSB first at one bit per clock. Every received byte is stored in a data memory organised as three rotating frame banks. A connection memory holds one entry per output channel. The entry names the source stream and source channel, a delay mode and an output enable. A synchronous CPU write port loads the connection memory, and each write takes effect at the next frame start.

Each output channel picks its own delay mode. In variable mode the sample leaves at the first output slot the frame timing permits. In constant mode every channel of an input frame leaves together two frames later, so that grouped data keeps its frame alignment. The switch is non-blocking: any input channel may feed any number of output channels in the same frame.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held and after it is released, every output channel is disabled (`tx_oe` low, `tx_out` low) until connection entries with the enable bit set have been written and committed.
- R2: A one-cycle `fp` pulse marks bit 0 of slot 0 on every stream. A frame is 256 bit periods, and slot s takes bit periods 8s to 8s+7, MSB first. Input and output frames are aligned.
- R3: A CPU write sets the entry at `cpu_addr` = {output stream[6:5], output slot[4:0]}. The entry fields in `cpu_wdata` are: bits [4:0] source channel, [6:5] source stream, [7] mode (0 variable, 1 constant), [8] output enable.
- R4: Entries written during frame M take effect from slot 0 of frame M+1, provided the write is made before the last two bit periods of frame M. Frame M keeps using the previous entries.
- R5: In variable mode, when the source slot is lower than the destination slot, the byte that arrived in that slot of frame M leaves in frame M. This holds for the adjacent slot too (source = destination - 1).
- R6: In variable mode, when the source slot is equal to or higher than the destination slot, the byte from frame M-1 leaves in frame M. This includes destination 0 fed from source slot 31.
- R7: In constant mode, the byte that arrived in frame N leaves in frame N+2 for every pair of source and destination slots.
- R8: An output channel whose enable bit is clear holds `tx_oe` low and `tx_out` low for all 8 bit periods of its slot. `tx_oe` changes only at slot boundaries.
- R9: One input channel may feed several output channels in the same frame, and those output channels may use different delay modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fp | input | 1 | Frame pulse, high during bit 0 of slot 0 |
| rx_in | input | 4 | Serial input streams, one bit each |
| cpu_we | input | 1 | Connection memory write strobe |
| cpu_addr | input | 7 | Output stream and output slot of the entry |
| cpu_wdata | input | 9 | Entry value: enable, mode, source stream, source channel |
| tx_out | output | 4 | Serial output streams, registered |
| tx_oe | output | 4 | Per-stream drive enable; low marks the slot high-impedance |

## Verification
The hardest corner is a variable-mode channel fed from the slot just before it. That byte completes in the same clock in which the output loads it. A design without a write-through path would send the byte from three frames earlier, or would send the wrong frame. Destination slot 0 fed from slot 31 tests the frame wrap: a wrong bank choice there shifts the sample by a whole frame. Constant mode is checked on every slot pair, including reversed slot orders, so an off-by-one in the bank rotation shows up as the wrong frame's data. Entries are rewritten in mid-frame, and the old entries must stay in force until the frame ends. A design that applied a write at once would show the new routing partway through the frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic {
    DLY_VARIABLE = 1'b0,
    DLY_CONSTANT = 1'b1
  } dly_mode_e;

  localparam int FRAME_BANKS = 3;

  // advance a frame bank index by n positions modulo FRAME_BANKS
  function automatic logic [1:0] bank_step(input logic [1:0] b, input logic [1:0] n);
    logic [2:0] s;
    s = {1'b0, b} + {1'b0, n};
    if (s >= 3'(FRAME_BANKS)) s = s - 3'(FRAME_BANKS);
    return s[1:0];
  endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_i,
  output logic [POS_W-1:0] pos_o,
  output logic [1:0]       bank_o
);

  logic [POS_W-1:0] cnt_q;
  logic [1:0]       bank_q;

  // the frame pulse forces position zero in the cycle it is seen
  assign pos_o  = fp_i ? '0 : cnt_q;
  assign bank_o = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bank_q <= 2'd0;
    end else begin
      cnt_q <= pos_o + POS_W'(1);
      if (pos_o == '1) bank_q <= bank_step(bank_q, 2'd1);
    end
  end

  a_r2_bank_rotates: assert property (@(posedge clk) disable iff (rst)
    (pos_o == '1) |=> (bank_o == bank_step($past(bank_o), 2'd1)));

  a_r2_bank_holds: assert property (@(posedge clk) disable iff (rst)
    (pos_o != '1) |=> $stable(bank_o));

  a_r2_bank_range: assert property (@(posedge clk) disable iff (rst)
    bank_o != 2'd3);

endmodule

// File: rtl/tsi_rx_deser.sv
module tsi_rx_deser #(
  parameter int NSTR  = 4,
  parameter int SW    = 8,
  parameter int BIT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BIT_W-1:0]     bit_idx_i,
  input  logic [NSTR-1:0]      rx_i,
  output logic                 we_o,
  output logic [NSTR*SW-1:0]   word_o
);

  // the byte is complete in its last bit period; write it in that cycle
  assign we_o = (bit_idx_i == BIT_W'(SW-1));

  for (genvar k = 0; k < NSTR; k++) begin : g_lane
    logic [SW-1:0] sr_q;

    assign word_o[k*SW +: SW] = {sr_q[SW-2:0], rx_i[k]};

    always_ff @(posedge clk) begin
      if (rst) sr_q <= '0;
      else     sr_q <= {sr_q[SW-2:0], rx_i[k]};
    end
  end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NSTR = 4,
  parameter int SW   = 8,
  parameter int NCH  = 32,
  localparam int STR_W  = $clog2(NSTR),
  localparam int CH_W   = $clog2(NCH),
  localparam int ADDR_W = 2 + CH_W
) (
  input  logic                   clk,
  input  logic                   we_i,
  input  logic [1:0]             wbank_i,
  input  logic [CH_W-1:0]        wslot_i,
  input  logic [NSTR*SW-1:0]     wword_i,
  input  logic [NSTR*2-1:0]      rd_bank_i,
  input  logic [NSTR*CH_W-1:0]   rd_slot_i,
  input  logic [NSTR*STR_W-1:0]  rd_str_i,
  output logic [NSTR*SW-1:0]     rd_byte_o
);

  // one word per (bank, slot) holding the bytes of all input streams
  logic [NSTR*SW-1:0] mem [0:(1<<ADDR_W)-1];
  logic [ADDR_W-1:0]  waddr;

  assign waddr = {wbank_i, wslot_i};

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr] <= wword_i;
  end

  for (genvar k = 0; k < NSTR; k++) begin : g_rd
    logic [ADDR_W-1:0]  raddr;
    logic [NSTR*SW-1:0] word;
    logic [STR_W-1:0]   sel;

    assign raddr = {rd_bank_i[k*2 +: 2], rd_slot_i[k*CH_W +: CH_W]};
    assign sel   = rd_str_i[k*STR_W +: STR_W];
    // write-through so a byte finishing this cycle can leave in the next slot
    assign word  = (we_i && (raddr == waddr)) ? wword_i : mem[raddr];
    assign rd_byte_o[k*SW +: SW] = word[sel*SW +: SW];
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NENT = 128,
  parameter int EW   = 9,
  parameter int NRD  = 4,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     waddr_i,
  input  logic [EW-1:0]        wentry_i,
  input  logic                 commit_i,
  input  logic [NRD*IDX_W-1:0] rd_idx_i,
  output logic [NRD*EW-1:0]    rd_entry_o
);

  logic [NENT-1:0][EW-1:0] shadow_q;
  logic [NENT-1:0][EW-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i)     shadow_q[waddr_i] <= wentry_i;
      if (commit_i) active_q <= shadow_q;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_entry_o[k*EW +: EW] = active_q[rd_idx_i[k*IDX_W +: IDX_W]];
  end

  a_r4_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(active_q));

  a_r4_commit_takes_shadow: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (active_q == $past(shadow_q)));

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [SW-1:0] data_i,
  input  logic          en_i,
  output logic          tx_o,
  output logic          oe_o
);

  logic [SW-1:0] sh_q;
  logic          tx_q;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      tx_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= {data_i[SW-2:0], 1'b0};
      tx_q <= en_i & data_i[SW-1];
      oe_q <= en_i;
    end else begin
      sh_q <= {sh_q[SW-2:0], 1'b0};
      tx_q <= oe_q & sh_q[SW-1];
    end
  end

  assign tx_o = tx_q;
  assign oe_o = oe_q;

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> !tx_q);

  a_r8_enable_per_slot: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(oe_q));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTR = 4,
  parameter int NCH  = 32,
  parameter int SW   = 8,
  localparam int STR_W = $clog2(NSTR),
  localparam int CH_W  = $clog2(NCH),
  localparam int EW    = CH_W + STR_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fp,
  input  logic [NSTR-1:0]       rx_in,
  input  logic                  cpu_we,
  input  logic [STR_W+CH_W-1:0] cpu_addr,
  input  logic [EW-1:0]         cpu_wdata,
  output logic [NSTR-1:0]       tx_out,
  output logic [NSTR-1:0]       tx_oe
);

  localparam int BIT_W = $clog2(SW);
  localparam int POS_W = CH_W + BIT_W;
  localparam int IDX_W = STR_W + CH_W;

  logic [POS_W-1:0] pos;
  logic [1:0]       wr_bank;
  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  cur_slot;
  logic [CH_W-1:0]  nxt_slot;
  logic             load;
  logic             commit;
  logic             wrap;

  tsi_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .fp_i   (fp),
    .pos_o  (pos),
    .bank_o (wr_bank)
  );

  assign bit_idx  = pos[BIT_W-1:0];
  assign cur_slot = pos[POS_W-1:BIT_W];
  assign nxt_slot = cur_slot + CH_W'(1);
  assign load     = (bit_idx == BIT_W'(SW-1));
  assign wrap     = (nxt_slot == '0);
  // entries switch just before slot 0 of the next frame is fetched
  assign commit   = (pos == POS_W'((1 << POS_W) - 2));

  logic                dm_we;
  logic [NSTR*SW-1:0]  dm_wword;

  tsi_rx_deser #(.NSTR(NSTR), .SW(SW), .BIT_W(BIT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .bit_idx_i (bit_idx),
    .rx_i      (rx_in),
    .we_o      (dm_we),
    .word_o    (dm_wword)
  );

  logic [NSTR*IDX_W-1:0] cm_idx;
  logic [NSTR*EW-1:0]    cm_entry;

  tsi_conn_mem #(.NENT(NSTR*NCH), .EW(EW), .NRD(NSTR)) u_conn (
    .clk        (clk),
    .rst        (rst),
    .we_i       (cpu_we),
    .waddr_i    (cpu_addr),
    .wentry_i   (cpu_wdata),
    .commit_i   (commit),
    .rd_idx_i   (cm_idx),
    .rd_entry_o (cm_entry)
  );

  logic [NSTR*2-1:0]     rd_bank;
  logic [NSTR*CH_W-1:0]  rd_slot;
  logic [NSTR*STR_W-1:0] rd_str;
  logic [NSTR*SW-1:0]    rd_byte;

  tsi_data_mem #(.NSTR(NSTR), .SW(SW), .NCH(NCH)) u_data (
    .clk       (clk),
    .we_i      (dm_we),
    .wbank_i   (wr_bank),
    .wslot_i   (cur_slot),
    .wword_i   (dm_wword),
    .rd_bank_i (rd_bank),
    .rd_slot_i (rd_slot),
    .rd_str_i  (rd_str),
    .rd_byte_o (rd_byte)
  );

  for (genvar k = 0; k < NSTR; k++) begin : g_out
    logic [EW-1:0]    ent;
    logic [CH_W-1:0]  src_ch;
    logic [STR_W-1:0] src_st;
    dly_mode_e        mode;
    logic             en;
    logic [1:0]       bank_sel;

    assign cm_idx[k*IDX_W +: IDX_W] = {STR_W'(k), nxt_slot};
    assign ent    = cm_entry[k*EW +: EW];
    assign src_ch = ent[CH_W-1:0];
    assign src_st = ent[CH_W +: STR_W];
    assign mode   = dly_mode_e'(ent[EW-2]);
    assign en     = ent[EW-1];

    // Bank choice at the load of output slot d of frame M.
    // When d is 0 the load falls in the last slot of frame M-1.
    always_comb begin
      if (mode == DLY_CONSTANT)
        bank_sel = wrap ? bank_step(wr_bank, 2'd2) : bank_step(wr_bank, 2'd1);
      else if (wrap || (src_ch < nxt_slot))
        bank_sel = wr_bank;
      else
        bank_sel = bank_step(wr_bank, 2'd2);
    end

    assign rd_bank[k*2 +: 2]         = bank_sel;
    assign rd_slot[k*CH_W +: CH_W]   = src_ch;
    assign rd_str[k*STR_W +: STR_W]  = src_st;

    tsi_tx_lane #(.SW(SW)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .data_i (rd_byte[k*SW +: SW]),
      .en_i   (en),
      .tx_o   (tx_out[k]),
      .oe_o   (tx_oe[k])
    );

    // R7: constant-delay reads never touch the bank being filled
    a_r7_const_bank_apart: assert property (@(posedge clk) disable iff (rst)
      (load && mode == DLY_CONSTANT) |-> (bank_sel != wr_bank));
  end

endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;

  localparam int NSTR  = 4;
  localparam int NCH   = 32;
  localparam int FLEN  = 256;
  localparam int NFR   = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp = 1'b0;
  logic [3:0] rx_in = '0;
  logic       cpu_we = 1'b0;
  logic [6:0] cpu_addr = '0;
  logic [8:0] cpu_wdata = '0;
  logic [3:0] tx_out;
  logic [3:0] tx_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tsi_switch u_dut (
    .clk       (clk),
    .rst       (rst),
    .fp        (fp),
    .rx_in     (rx_in),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .tx_out    (tx_out),
    .tx_oe     (tx_oe)
  );

  // byte on stream st, slot sl of input frame f; differs frame to frame
  function automatic logic [7:0] rxbyte(input int f, input int st, input int sl);
    return 8'((f * 97 + st * 53 + sl * 29 + 17) & 255);
  endfunction

  // entry {oe, mode, stream[1:0], channel[4:0]} for variant v, output k, slot d
  function automatic logic [8:0] cfg(input int v, input int k, input int d);
    int ch, st, md, oe;
    case (v)
      0: begin ch = (d + 31) % 32; st = (k + 1) % 4; md = 0; oe = (d == 7 && k == 2) ? 0 : 1; end
      1: begin ch = d; st = (k + d) % 4; md = (d % 3 == 0) ? 1 : 0; oe = ((d + k) % 5 == 1) ? 0 : 1; end
      2: begin ch = 31 - d; st = 3 - k; md = (d + k) % 2; oe = 1; end
      default: begin ch = 5; st = 0; md = k % 2; oe = 1; end
    endcase
    return {1'(oe), 1'(md), 2'(st), 5'(ch)};
  endfunction

  task automatic check(input string tag, input string tag2, input int k,
                       input logic got_oe, input logic got_tx,
                       input logic exp_oe, input logic exp_tx, input bit cmp_tx);
    n_chk++;
    if (got_oe !== exp_oe || (cmp_tx && got_tx !== exp_tx)) begin
      n_bad++;
      $display("FAIL %s/%s stream %0d: oe=%b tx=%b expected oe=%b tx=%b",
               tag, tag2, k, got_oe, got_tx, exp_oe, exp_tx);
    end
  endtask

  logic [8:0] pend [NSTR][NCH];
  logic [8:0] cur  [NSTR][NCH];

  initial begin
    for (int k = 0; k < NSTR; k++)
      for (int d = 0; d < NCH; d++) begin
        pend[k][d] = '0;
        cur[k][d]  = '0;
      end
    repeat (4) @(negedge clk);
    // reset state, still in reset (R1)
    check("R1", "R2", 0, tx_oe[0], tx_out[0], 1'b0, 1'b0, 1'b1);
    for (int cyc = 0; cyc < NFR * FLEN; cyc++) begin
      int f, p, d, b;
      if (cyc > 0) @(negedge clk);
      f = cyc / FLEN;
      p = cyc % FLEN;
      d = p / 8;
      b = p % 8;
      rst = 1'b0;
      if (p == 0)
        for (int k = 0; k < NSTR; k++)
          for (int j = 0; j < NCH; j++) cur[k][j] = pend[k][j];
      // check outputs of this bit period
      for (int k = 0; k < NSTR; k++) begin
        logic [8:0] e;
        logic [7:0] bx;
        string tag, tag2;
        int s, srcf;
        e = cur[k][d];
        s = int'(e[4:0]);
        tag2 = (d == 0) ? "R2" : "R3";
        if (f == 0) tag = "R1";
        else if (f >= 10) tag = "R9";
        else if (!e[8]) tag = "R8";
        else if (f % 3 == 0) tag = "R4";
        else if (e[7]) tag = "R7";
        else if (s < d) tag = "R5";
        else tag = "R6";
        if (!e[8]) begin
          check(tag, tag2, k, tx_oe[k], tx_out[k], 1'b0, 1'b0, 1'b1);
        end else begin
          srcf = e[7] ? f - 2 : ((s < d) ? f : f - 1);
          if (srcf < 0) begin
            check(tag, tag2, k, tx_oe[k], tx_out[k], 1'b1, 1'b0, 1'b0);
          end else begin
            bx = rxbyte(srcf, int'(e[6:5]), s);
            check(tag, tag2, k, tx_oe[k], tx_out[k], 1'b1, bx[7 - b], 1'b1);
          end
        end
      end
      // drive inputs for this bit period
      fp = (p == 0);
      for (int k = 0; k < NSTR; k++) begin
        logic [7:0] rb;
        rb = rxbyte(f, k, d);
        rx_in[k] = rb[7 - b];
      end
      if ((f % 3 == 0) && (f / 3 < 4) && p >= 8 && p < 8 + NSTR * NCH) begin
        int idx, k, j;
        idx = p - 8;
        k = idx / NCH;
        j = idx % NCH;
        cpu_we    = 1'b1;
        cpu_addr  = {2'(k), 5'(j)};
        cpu_wdata = cfg(f / 3, k, j);
        pend[k][j] = cpu_wdata;
      end else begin
        cpu_we = 1'b0;
      end
    end
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule